// File: doc/BRIEF.md
# Prescaled Interval/Match Timer Channel

One 16-bit timer channel. An optional power-of-two prescaler produces step ticks from the input clock. On each tick the count moves up or down by one. It wraps either at full scale or at a programmed interval value. Three compare values are checked against the count on every tick. Each wrap or compare hit sets its own bit in a 6-bit sticky status vector. One level interrupt is raised while any status bit that is enabled in a mask is set.

The channel control word is held inside the block and written through a strobe. One bit of that word is an action bit: it zeroes the count and is not stored. The clock setting, interval, compare values, interrupt mask and status-clear mask are plain inputs, sampled every cycle.

Top module: `tmr_channel`

## Requirements
- R1: With pre_en low and the channel running, the count changes by one on every clock edge.
- R2: With pre_en high, the count changes once every 2^(pre_sel+1) clocks. The first step comes on the 2^(pre_sel+1)-th edge after a control write.
- R3: Control bit 0 set stops counting; the count holds its value. Bit 1 selects interval wrap, bit 2 selects down counting and bit 3 enables the compares.
- R4: In interval mode counting up runs 0..interval, then returns to 0. That wrap sets status bit 0.
- R5: In full-scale mode the count runs 0..0xFFFF. Each wrap, in either direction, sets status bit 4.
- R6: Counting down from 0 reloads the top value: interval in interval mode, 0xFFFF otherwise. This is also a wrap.
- R7: Lane k of cmp_vals (bits 16k+15:16k) sets status bit k+1 on a tick whose pre-step count equals it. This needs match enable, and the lane must not exceed the active top value.
- R8: irq is high exactly while (status & irq_mask) is nonzero, with no added delay.
- R9: On a control write, the stored word is the write data with bit 4 forced to 0. Bit 4 set also zeroes the count. The write cycle performs no count step and restarts the prescaler.
- R10: After reset the control word reads 0x21, the count is 0, status is 0 and the channel is stopped.
- R11: A set bit in stat_clr clears that status bit on the next edge. If an event for the same bit lands on that edge, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_en | input | 1 | Prescaler enable |
| pre_sel | input | 4 | Prescale exponent N, divide by 2^(N+1) |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control write data |
| interval | input | 16 | Interval-mode top value |
| cmp_vals | input | 48 | Three compare values, lane k in bits 16k+15:16k |
| irq_mask | input | 6 | Interrupt enable mask |
| stat_clr | input | 6 | Status clear strobe, one bit per status bit |
| ctl_rdata | output | 6 | Stored control word |
| count | output | 16 | Live count |
| status | output | 6 | Sticky status vector |
| irq | output | 1 | Level interrupt |

## Verification
A count step or a status change made on a tick is visible one clock after that edge. A control write is visible in ctl_rdata and, for a clear, in count one edge later, and it takes no step. irq follows status and irq_mask combinationally. The bench drives inputs and samples outputs at the falling edge. It counts rising edges exactly from a known restart point (a control write with the clear bit). For the mask-only irq checks it samples 1 ns after changing the mask.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W   = 16;
  localparam int SEL_W   = 4;
  localparam int NUM_CMP = 3;
  localparam int ST_W    = 6;
  localparam int CTL_W   = 6;
  // control word bit positions
  localparam int CTL_STOP  = 0;
  localparam int CTL_IVAL  = 1;
  localparam int CTL_DOWN  = 2;
  localparam int CTL_MATCH = 3;
  localparam int CTL_CLR   = 4;
  // status bit positions
  localparam int ST_IWRAP = 0;
  localparam int ST_OWRAP = 4;
  localparam logic [CTL_W-1:0] CTL_RESET = 6'h21;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             pre_en,
  input  logic [SEL_W-1:0] pre_sel,
  output logic             tick
);
  localparam int DIV_W = 1 << SEL_W;

  logic [DIV_W-1:0] pcnt_q, pcnt_d;
  logic [DIV_W:0]   mask_full;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask_full = ({{DIV_W{1'b0}}, 1'b1} << ({1'b0, pre_sel} + 1'b1)) - 1'b1;
    mask      = mask_full[DIV_W-1:0];
    tick      = run && !restart && (!pre_en || ((pcnt_q & mask) == mask));
    if (restart)  pcnt_d = '0;
    else if (run) pcnt_d = pcnt_q + 1'b1;
    else          pcnt_d = pcnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R2: with the prescaler on, two ticks never come back to back
  a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pre_en) |=> !(tick && pre_en));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             down,
  input  logic             ival,
  input  logic             clear,
  input  logic [CNT_W-1:0] interval,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] top,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    top   = ival ? interval : {CNT_W{1'b1}};
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (clear) begin
      cnt_d = '0;
    end else if (tick) begin
      if (down) begin
        if (cnt_q == '0) begin
          cnt_d = top;
          wrap  = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end else if (cnt_q >= top) begin
        cnt_d = '0;
        wrap  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R3: no tick and no clear leaves the count unchanged
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear) |=> $stable(cnt_q));
  // R4: an up wrap lands on zero
  a_r4_up_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clear && !down && wrap) |=> (cnt_q == '0));
  // R9: a clearing write zeroes the count
  a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_status.sv
module tmr_status #(
  parameter int CNT_W   = 16,
  parameter int NUM_CMP = 3,
  parameter int ST_W    = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic                     match_en,
  input  logic                     ival,
  input  logic                     wrap,
  input  logic [CNT_W-1:0]         count,
  input  logic [CNT_W-1:0]         top,
  input  logic [NUM_CMP*CNT_W-1:0] cmp_vals,
  input  logic [ST_W-1:0]          clr,
  input  logic [ST_W-1:0]          mask,
  output logic [ST_W-1:0]          status,
  output logic                     irq
);
  import tmr_pkg::*;

  logic [ST_W-1:0]    st_q, st_d, evt;
  logic [NUM_CMP-1:0] hit;

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    logic [CNT_W-1:0] lane;
    assign lane   = cmp_vals[k*CNT_W +: CNT_W];
    assign hit[k] = tick && match_en && (count == lane) && (lane <= top);
  end

  always_comb begin
    evt           = '0;
    evt[ST_IWRAP] = wrap && ival;
    evt[ST_OWRAP] = wrap && !ival;
    for (int k = 0; k < NUM_CMP; k++) evt[k+1] = hit[k];
    st_d = (st_q & ~clr) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign status = st_q;
  assign irq    = |(st_q & mask);

  // R11: an event bit is set after its edge, even under a clear
  a_r11_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((st_q & $past(evt)) == $past(evt)));
  // R7: compare hits need match enable
  a_r7_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !match_en |-> (hit == '0));
  // R8: empty status never raises the interrupt
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == '0) |-> !irq);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int P_CNT_W   = tmr_pkg::CNT_W,
  parameter int P_SEL_W   = tmr_pkg::SEL_W,
  parameter int P_NUM_CMP = tmr_pkg::NUM_CMP
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pre_en,
  input  logic [P_SEL_W-1:0]           pre_sel,
  input  logic                         ctl_we,
  input  logic [CTL_W-1:0]             ctl_wdata,
  input  logic [P_CNT_W-1:0]           interval,
  input  logic [P_NUM_CMP*P_CNT_W-1:0] cmp_vals,
  input  logic [ST_W-1:0]              irq_mask,
  input  logic [ST_W-1:0]              stat_clr,
  output logic [CTL_W-1:0]             ctl_rdata,
  output logic [P_CNT_W-1:0]           count,
  output logic [ST_W-1:0]              status,
  output logic                         irq
);
  localparam logic [CTL_W-1:0] CLR_MASK = CTL_W'(1) << CTL_CLR;

  logic [CTL_W-1:0]   ctl_q, ctl_d;
  logic               tick, wrap, clear;
  logic [P_CNT_W-1:0] top;

  always_comb begin
    ctl_d = ctl_we ? (ctl_wdata & ~CLR_MASK) : ctl_q;
    clear = ctl_we && ctl_wdata[CTL_CLR];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RESET;
    else        ctl_q <= ctl_d;
  end

  assign ctl_rdata = ctl_q;

  tmr_prescale #(.SEL_W(P_SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(!ctl_q[CTL_STOP]), .restart(ctl_we),
    .pre_en(pre_en), .pre_sel(pre_sel), .tick(tick)
  );

  tmr_counter #(.CNT_W(P_CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .down(ctl_q[CTL_DOWN]),
    .ival(ctl_q[CTL_IVAL]), .clear(clear), .interval(interval),
    .count(count), .top(top), .wrap(wrap)
  );

  tmr_status #(.CNT_W(P_CNT_W), .NUM_CMP(P_NUM_CMP), .ST_W(ST_W)) u_st (
    .clk(clk), .rst_n(rst_n), .tick(tick), .match_en(ctl_q[CTL_MATCH]),
    .ival(ctl_q[CTL_IVAL]), .wrap(wrap), .count(count), .top(top),
    .cmp_vals(cmp_vals), .clr(stat_clr), .mask(irq_mask),
    .status(status), .irq(irq)
  );

  // R9: the action bit never reaches the stored word
  a_r9_clr_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> !ctl_rdata[CTL_CLR]);
  // R3: a stopped channel holds its count
  a_r3_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[CTL_STOP] && !ctl_we) |=> $stable(count));
endmodule

// File: tb/sim_tmr_channel.sv
module sim_tmr_channel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pre_en;
  logic [3:0]  pre_sel;
  logic        ctl_we;
  logic [5:0]  ctl_wdata;
  logic [15:0] interval;
  logic [47:0] cmp_vals;
  logic [5:0]  irq_mask;
  logic [5:0]  stat_clr;
  logic [5:0]  ctl_rdata;
  logic [15:0] count;
  logic [5:0]  status;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tmr_channel u0 (
    .clk(clk), .rst_n(rst_n), .pre_en(pre_en), .pre_sel(pre_sel),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .interval(interval),
    .cmp_vals(cmp_vals), .irq_mask(irq_mask), .stat_clr(stat_clr),
    .ctl_rdata(ctl_rdata), .count(count), .status(status), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [5:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  // stop and zero, clear all status, then start in the given mode
  task automatic setup(input logic [5:0] mode);
    wr_ctl(mode | 6'h11);
    stat_clr = 6'h3F;
    @(negedge clk);
    stat_clr = 6'h00;
    wr_ctl(mode | 6'h10);
  endtask

  task automatic t_reset;
    chk("R10 ctl", ctl_rdata, 6'h21);
    chk("R10 count", count, 0);
    chk("R10 status", status, 0);
    chk("R10 irq", irq, 0);
    step(3);
    chk("R10 stopped", count, 0);
  endtask

  task automatic t_plain_count;
    pre_en = 1'b0;
    setup(6'h00);
    chk("R9 write no step", count, 0);
    step(5);
    chk("R1 five clocks", count, 5);
  endtask

  task automatic t_prescale;
    pre_en = 1'b1; pre_sel = 4'd1;
    setup(6'h00);
    step(3);
    chk("R2 before tick", count, 0);
    step(1);
    chk("R2 first tick", count, 1);
    step(4);
    chk("R2 second tick", count, 2);
    pre_en = 1'b0; pre_sel = 4'd0;
  endtask

  task automatic t_interval_up;
    interval = 16'd3;
    setup(6'h02);
    step(3);
    chk("R4 at top", count, 3);
    chk("R4 no wrap yet", status, 0);
    step(1);
    chk("R4 wrapped count", count, 0);
    chk("R4 wrap bit0", status, 6'h01);
  endtask

  task automatic t_down;
    interval = 16'd3;
    setup(6'h06);
    step(1);
    chk("R6 interval reload", count, 3);
    chk("R6 interval wrap bit0", status, 6'h01);
    setup(6'h04);
    step(1);
    chk("R6 full reload", count, 16'hFFFF);
    chk("R5 down wrap bit4", status, 6'h10);
    stat_clr = 6'h10;
    @(negedge clk);
    stat_clr = 6'h00;
    chk("R11 clear bit4", status, 0);
    chk("R6 down step", count, 16'hFFFE);
    wr_ctl(6'h00);
    step(1);
    chk("R5 at full scale", count, 16'hFFFF);
    step(1);
    chk("R5 up wrap count", count, 0);
    chk("R5 up wrap bit4", status, 6'h10);
  endtask

  task automatic t_match;
    interval = 16'd10;
    cmp_vals = {16'd12, 16'd5, 16'd2};
    setup(6'h0A);
    step(2);
    chk("R7 before hit", status, 0);
    step(1);
    chk("R7 lane0 bit1", status, 6'h02);
    step(3);
    chk("R7 lane1 bit2", status, 6'h06);
    step(5);
    chk("R7 lane2 beyond top silent", status, 6'h07);
    setup(6'h02);
    step(11);
    chk("R7 compares off", status, 6'h01);
  endtask

  task automatic t_irq;
    setup(6'h0A);
    step(11);
    irq_mask = 6'h00; #1;
    chk("R8 masked", irq, 0);
    irq_mask = 6'h08; #1;
    chk("R8 unset bit", irq, 0);
    irq_mask = 6'h04; #1;
    chk("R8 enabled bit", irq, 1);
    @(negedge clk);
    irq_mask = 6'h00;
  endtask

  task automatic t_ctl;
    setup(6'h00);
    step(2);
    wr_ctl(6'h01);
    chk("R3 stop write", count, 2);
    step(5);
    chk("R3 stopped hold", count, 2);
    wr_ctl(6'h1F);
    chk("R9 bit4 reads zero", ctl_rdata, 6'h0F);
    chk("R9 bit4 clears count", count, 0);
  endtask

  task automatic t_collide;
    interval = 16'd3;
    cmp_vals = '0;
    setup(6'h02);
    step(3);
    stat_clr = 6'h01;
    @(negedge clk);
    stat_clr = 6'h00;
    chk("R11 event beats clear", status, 6'h01);
    stat_clr = 6'h01;
    @(negedge clk);
    stat_clr = 6'h00;
    chk("R11 plain clear", status, 0);
  endtask

  initial begin
    rst_n = 1'b0; pre_en = 1'b0; pre_sel = '0; ctl_we = 1'b0; ctl_wdata = '0;
    interval = '0; cmp_vals = '0; irq_mask = '0; stat_clr = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_plain_count();
    t_prescale();
    t_interval_up();
    t_down();
    t_match();
    t_irq();
    t_ctl();
    t_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule